// File: doc/BRIEF.md
# Word-Serial Multiplier over GF(2^m) in Folded Normal Coordinates

This block multiplies two elements of the binary field GF(2^m). Both operands and the product use a permuted optimal normal basis of the second type, which exists when 2m+1 is prime. In these coordinates coefficient index x is folded onto the range 0..m by s(x): let r = x mod (2m+1); s(x) = r when r <= m, and s(x) = 2m+1-r otherwise. Coefficient b_0 counts as zero. Product bit i, for i = 1..m, is c_i = XOR over j = 1..m of a_j AND (b_s(i+j) XOR b_s(i-j)).

A start pulse captures operand B into a rotating register of 2m+1 bits and clears every accumulator. Over the next W cycles operand A arrives in comb order: D = ceil(M/W) bits per cycle, with bit k of the input carrying the l-th bit of word k. Each cycle, every accumulator XORs in one AND-gated term from fixed taps of the rotating register, so the path between registers is one AND plus one XOR whatever M or D is. After the W-th step, done rises and the product is held until the next start. A parameter selects between separate accumulators for the rising-index and falling-index B terms (variant a), or a single accumulator that ANDs the XOR of both B bits (variant b).

Top module: `rnb_mult`

## Requirements
- R1: While reset is held and in the first cycle after it, done is 0 and c is all zeros.
- R2: A start sampled high on a rising edge loads B and clears all accumulators, so in the cycle after that edge done is 0 and c is all zeros.
- R3: On the l-th rising edge after the start edge (l = 1..W), bit k of a_bits is taken as coefficient a_(kW+l) of operand A (comb order).
- R4: done rises exactly W rising edges after the edge that sampled start, and c then equals XOR over j of a_j AND (b_s(i+j) XOR b_s(i-j)) for every i = 1..M, with b_0 = 0.
- R5: Once done is high, done and c stay unchanged until the next start, whatever is driven on a_bits.
- R6: An a_bits bit whose coefficient index kW+l exceeds M has no effect on the product.
- R7: With A all ones (the field identity), c equals b_load.
- R8: A start that arrives before the W steps are complete abandons the running product: done stays 0 and the new operands are multiplied from the beginning.
- R9: Variant a (VARIANT = 0) and variant b (VARIANT = 1) produce the same c for the same operands.
- R10: A zero operand A gives c all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load B, clear accumulators, begin a product |
| a_bits | input | D | Comb-ordered A slice: bit k is a_(kW+l) in step l |
| b_load | input | M | Operand B, bit i is coefficient b_i (indices M:1) |
| done | output | 1 | Product complete and held |
| c | output | M | Product, bit i is coefficient c_i (indices M:1) |

## Verification
The edge that samples start clears everything, so the cycle after it must already show done low and a zero product; the A slices are then due on the next W edges, one per edge, and the product is due on the W-th one, when done rises. The driver presents each slice on the falling edge before the rising edge that consumes it and queues the expected product before the first slice, while the monitor samples on falling edges, pops the queue when done rises and compares both variants and the edge count since start against W. For the hold, junk slices are driven for several cycles after done and the product is rechecked on each falling edge.

// File: rtl/rnb_pkg.sv
package rnb_pkg;

   // non-negative residue of x modulo p
   function automatic int pos_mod(input int x, input int p);
      int r;
      r = x % p;
      if (r < 0) r = r + p;
      return r;
   endfunction

   // fold an arbitrary index onto 0..m
   function automatic int fold_idx(input int x, input int m);
      int r;
      r = pos_mod(x, 2 * m + 1);
      return (r <= m) ? r : (2 * m + 1 - r);
   endfunction

   function automatic bit is_prime(input int n);
      bit ok;
      ok = (n >= 2);
      for (int q = 2; q * q <= n; q++) begin
         if (n % q == 0) ok = 1'b0;
      end
      return ok;
   endfunction

   // register position feeding the rising-index term of output i, word k
   function automatic int tap_up(input int i, input int k, input int w, input int m);
      return pos_mod(i + k * w + 1, 2 * m + 1);
   endfunction

   // register position feeding the falling-index term of output i, word k
   function automatic int tap_dn(input int i, input int k, input int w, input int m);
      return pos_mod(k * w + 1 - i, 2 * m + 1);
   endfunction

endpackage

// File: rtl/rnb_breg.sv
module rnb_breg #(
   parameter int M = 11,
   localparam int P = 2 * M + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [M:1]   b_in,
   output logic [P-1:0] r_q
);

   logic [P-1:0] ld_val;

   // position j holds b_s(j); position 0 maps to b_0 which is zero
   for (genvar j = 0; j < P; j++) begin : g_pos
      localparam int SJ = rnb_pkg::fold_idx(j, M);
      if (SJ == 0) begin : g_zero
         assign ld_val[j] = 1'b0;
      end else begin : g_bit
         assign ld_val[j] = b_in[SJ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
      end else if (load) begin
         r_q <= ld_val;
      end else if (shift) begin
         // after r shifts, position j holds b_s(j + r)
         r_q <= {r_q[0], r_q[P-1:1]};
      end
   end

endmodule

// File: rtl/rnb_ctrl.sv
module rnb_ctrl #(
   parameter int W = 4,
   localparam int SW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [SW-1:0] step,
   output logic          done
);

   localparam logic [SW-1:0] LAST = SW'(W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         step <= SW'(1);
         done <= 1'b0;
      end else if (busy) begin
         if (step == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            step <= step + SW'(1);
         end
      end
   end

endmodule

// File: rtl/rnb_acc_array.sv
module rnb_acc_array #(
   parameter int M       = 11,
   parameter int W       = 4,
   parameter int VARIANT = 0,
   localparam int D  = (M + W - 1) / W,
   localparam int P  = 2 * M + 1,
   localparam int SW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [SW-1:0] step,
   input  logic [D-1:0]  a_bits,
   input  logic [P-1:0]  r_q,
   output logic [M:1]    c
);

   logic [D-1:0] a_eff;

   // coefficient index k*W+step beyond M contributes nothing
   for (genvar k = 0; k < D; k++) begin : g_amask
      assign a_eff[k] = a_bits[k] && ((k * W + int'(step)) <= M);
   end

   if (VARIANT == 0) begin : g_split
      for (genvar i = 1; i <= M; i++) begin : g_bit
         logic [D-1:0] t_up, t_dn;
         logic [D-1:0] acc_up, acc_dn;
         for (genvar k = 0; k < D; k++) begin : g_word
            localparam int PU = rnb_pkg::tap_up(i, k, W, M);
            localparam int PD = rnb_pkg::tap_dn(i, k, W, M);
            assign t_up[k] = a_eff[k] & r_q[PU];
            assign t_dn[k] = a_eff[k] & r_q[PD];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_up <= '0;
               acc_dn <= '0;
            end else if (clr) begin
               acc_up <= '0;
               acc_dn <= '0;
            end else if (en) begin
               acc_up <= acc_up ^ t_up;
               acc_dn <= acc_dn ^ t_dn;
            end
         end
         assign c[i] = (^acc_up) ^ (^acc_dn);
      end
   end else begin : g_merged
      for (genvar i = 1; i <= M; i++) begin : g_bit
         logic [D-1:0] t_sum;
         logic [D-1:0] acc;
         for (genvar k = 0; k < D; k++) begin : g_word
            localparam int PU = rnb_pkg::tap_up(i, k, W, M);
            localparam int PD = rnb_pkg::tap_dn(i, k, W, M);
            assign t_sum[k] = a_eff[k] & (r_q[PU] ^ r_q[PD]);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc <= '0;
            end else if (clr) begin
               acc <= '0;
            end else if (en) begin
               acc <= acc ^ t_sum;
            end
         end
         assign c[i] = ^acc;
      end
   end

endmodule

// File: rtl/rnb_mult.sv
module rnb_mult #(
   parameter int M       = 11,
   parameter int W       = 4,
   parameter int VARIANT = 0,
   localparam int D  = (M + W - 1) / W,
   localparam int P  = 2 * M + 1,
   localparam int SW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [D-1:0] a_bits,
   input  logic [M:1]   b_load,
   output logic         done,
   output logic [M:1]   c
);

   if (M < 2) begin : g_chk_m
      $error("rnb_mult: M must be at least 2");
   end
   if (!rnb_pkg::is_prime(P)) begin : g_chk_p
      $error("rnb_mult: 2*M+1 must be prime");
   end
   if (W < 1 || W > M) begin : g_chk_w
      $error("rnb_mult: W must lie in 1..M");
   end
   if (VARIANT != 0 && VARIANT != 1) begin : g_chk_v
      $error("rnb_mult: VARIANT must be 0 or 1");
   end

   logic          busy;
   logic [SW-1:0] step;
   logic [P-1:0]  r_q;

   rnb_ctrl #(.W(W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .step  (step),
      .done  (done)
   );

   rnb_breg #(.M(M)) u_breg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .shift (busy && !start),
      .b_in  (b_load),
      .r_q   (r_q)
   );

   rnb_acc_array #(.M(M), .W(W), .VARIANT(VARIANT)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .en     (busy && !start),
      .step   (step),
      .a_bits (a_bits),
      .r_q    (r_q),
      .c      (c)
   );

endmodule

// File: rtl/rnb_mult_chk.sv
module rnb_mult_chk #(
   parameter int M = 11,
   parameter int W = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       done,
   input logic [M:1] c
);

   int since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           since <= W + 1;
      else if (start)       since <= 0;
      else if (since <= W)  since <= since + 1;
   end

   assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done && c == '0));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && c == '0));

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (since == W));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(c)));

endmodule

bind rnb_mult rnb_mult_chk #(.M(M), .W(W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .done  (done),
   .c     (c)
);

// File: tb/rnb_mult_tb.sv
module rnb_mult_tb;

   localparam int M = 11;
   localparam int W = 4;
   localparam int D = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [D-1:0] a_bits = '0;
   logic [M:1]   b_load = '0;
   logic         done, done_b;
   logic [M:1]   c, c_b;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int start_cyc = 0;
   bit done_q = 1'b0;
   logic [M:1] exp_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rnb_mult #(.M(M), .W(W), .VARIANT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_bits(a_bits),
      .b_load(b_load), .done(done), .c(c));

   rnb_mult #(.M(M), .W(W), .VARIANT(1)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .start(start), .a_bits(a_bits),
      .b_load(b_load), .done(done_b), .c(c_b));

   task automatic chk(input bit ok, input string req, input logic [M:1] act,
                      input logic [M:1] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int fold(input int x);
      int r;
      r = x % (2 * M + 1);
      if (r < 0) r += 2 * M + 1;
      if (r > M) r = 2 * M + 1 - r;
      return r;
   endfunction

   function automatic logic bsel(input logic [M:1] b, input int x);
      int s;
      s = fold(x);
      return (s == 0) ? 1'b0 : b[s];
   endfunction

   function automatic logic [M:1] model(input logic [M:1] a, input logic [M:1] b);
      logic [M:1] r;
      for (int i = 1; i <= M; i++) begin
         logic t;
         t = 1'b0;
         for (int j = 1; j <= M; j++) t ^= a[j] & (bsel(b, i + j) ^ bsel(b, i - j));
         r[i] = t;
      end
      return r;
   endfunction

   // drive one product; steps < W aborts before completion
   task automatic run_mul(input logic [M:1] a, input logic [M:1] b,
                          input int steps, input bit junk);
      if (steps == W) exp_q.push_back(model(a, b));
      @(negedge clk);
      start  = 1'b1;
      b_load = b;
      a_bits = D'($urandom);
      @(negedge clk);
      start     = 1'b0;
      start_cyc = cyc;
      chk(!done && c == '0, "R2 clear after start", c, '0);
      for (int l = 1; l <= steps; l++) begin
         for (int k = 0; k < D; k++) begin
            int idx;
            idx = k * W + l;
            a_bits[k] = (idx <= M) ? a[idx] : junk;
         end
         @(negedge clk);
      end
   endtask

   // after done, junk on a_bits must not disturb the held result
   task automatic hold_check(input logic [M:1] exp, input int n);
      for (int t = 0; t < n; t++) begin
         a_bits = D'($urandom);
         @(negedge clk);
         chk(done && c == exp, "R5 hold after done", c, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && done && !done_q) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected done", c, '0);
         end else begin
            logic [M:1] e;
            e = exp_q.pop_front();
            chk(c == e, "R4 product value", c, e);
            chk(c_b == e && done_b, "R9 variant b matches", c_b, e);
            chk((cyc - start_cyc) == W, "R4 latency", M'(cyc - start_cyc), M'(W));
         end
      end
      done_q = done;
   end

   initial begin
      #20_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [M:1] a, b, e;
      repeat (3) @(negedge clk);
      chk(!done && c == '0, "R1 reset state a", c, '0);
      chk(!done_b && c_b == '0, "R1 reset state b", c_b, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && c == '0, "R1 first cycle after reset", c, '0);

      // R10: zero A
      b = 11'h5a3;
      run_mul('0, b, W, 1'b0);
      chk(c == '0, "R10 zero operand", c, '0);
      hold_check('0, 2);

      // R7: identity
      for (int t = 0; t < 4; t++) begin
         b = M'($urandom);
         run_mul('1, b, W, 1'b0);
         chk(c == b, "R7 identity gives B", c, b);
      end

      // R3: single coefficients check comb order
      for (int j = 1; j <= M; j++) begin
         a = '0;
         a[j] = 1'b1;
         b = M'($urandom);
         run_mul(a, b, W, 1'b0);
         e = model(a, b);
         chk(c == e, "R3 comb order single bit", c, e);
      end

      // R4/R5: random pairs with hold
      for (int t = 0; t < 20; t++) begin
         a = M'($urandom);
         b = M'($urandom);
         run_mul(a, b, W, 1'b0);
         e = model(a, b);
         hold_check(e, 3);
      end

      // R6: out-of-range slots driven high
      for (int t = 0; t < 5; t++) begin
         a = M'($urandom);
         b = M'($urandom);
         run_mul(a, b, W, 1'b1);
         e = model(a, b);
         chk(c == e, "R6 out-of-range bits ignored", c, e);
      end

      // R8: restart mid-product
      a = M'($urandom);
      b = M'($urandom);
      run_mul(a, b, 2, 1'b0);
      chk(!done, "R8 no done after abort", {10'b0, done}, '0);
      a = M'($urandom);
      b = M'($urandom);
      run_mul(a, b, W, 1'b0);
      e = model(a, b);
      chk(c == e, "R8 restart result", c, e);

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all results delivered", M'(exp_q.size()), '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule